// File: doc/BRIEF.md
# Protected-Mode Segment Descriptor Unit

This unit keeps a hidden copy of the descriptor for each segment register of a protected-mode core. A selector write to one of the segment slots starts a descriptor fetch. The fetch uses the global table or the local table, depending on the selector. It makes two 32-bit reads through a simple synchronous read port. The unit then decodes base, limit, rights, granularity and operand-size bits into that slot's cache entry. From then on, every memory access through that slot is translated to a linear address and checked for limit and write-protection violations from the cached copy, without touching the table again.

The two table-base registers (base plus byte limit) are written through a small control port. While a fetch is in flight the unit raises `busy`. Loads and accesses presented during that time are not taken, so a requester holds its request until the unit is idle. Slot 0 is the code slot and slot 1 the stack slot. These are the strict slots, which refuse a null selector. The remaining slots are data slots.

Top module: `seg_desc_unit`

## Requirements
- R1: After synchronous reset `busy`, `ld_done`, `acc_done` and `mem_rd_en` are 0, and every slot behaves as holding a null selector.
- R2: A selector carries its table index in bits 15:3, the table choice in bit 2 (0 global, 1 local) and a requested level in bits 1:0. An accepted load reads the 32-bit words at table base + index*8 and then at +4, on two consecutive cycles. `busy` is high from the cycle after acceptance until `ld_done` pulses.
- R3: If index*8+7 exceeds the chosen table's limit, the load ends with `ld_fault`=2 one cycle after acceptance. No read is issued and the slot keeps its previous descriptor.
- R4: A null selector (index 0, bit 2 clear, any level) written to slot 0 or 1 ends with `ld_fault`=1 one cycle after acceptance, with no read, and the slot is unchanged.
- R5: A null selector written to a data slot loads without fault (`ld_fault`=0). Every later access through that slot, and any access through a slot never loaded since reset, reports `acc_fault`=1.
- R6: The descriptor layout is as follows. Word 0 bits 15:0 hold limit 15:0 and bits 31:16 hold base 15:0. Word 1 bits 7:0 hold base 23:16, bits 15:8 the rights byte, bits 19:16 limit 19:4... more exactly limit 19:16, bit 22 the size bit, bit 23 the granularity bit, and bits 31:24 base 31:24. A clean access returns `acc_linear` = base + offset.
- R7: With granularity 0 the effective limit is the 20-bit limit. With granularity 1 it is the limit shifted left by 12 with FFFh filled in below.
- R8: An offset above the effective limit reports `acc_fault`=2. An offset equal to the limit is accepted.
- R9: A write is allowed only when rights bit 3 is 0 and rights bit 1 is 1; otherwise a write reports `acc_fault`=3. Null outranks limit, and limit outranks write protection.
- R10: With size bit 0, offset bits 31:16 are ignored for both the limit check and the address sum. With size bit 1 all 32 bits are used.
- R11: Accesses use only the cached copy. They issue no reads, and changes to table memory after a load have no effect until the slot is reloaded.
- R12: Loads and accesses are taken only while `busy` is 0. Each taken access gives exactly one `acc_done` pulse one cycle later.
- R13: A faulting access returns `acc_linear` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Write one table-base register |
| tbl_wr_local | input | 1 | 0 selects the global table register, 1 the local one |
| tbl_wr_base | input | 32 | Table base byte address |
| tbl_wr_limit | input | TBL_LIM_W | Table limit in bytes |
| ld_valid | input | 1 | Selector write request |
| ld_seg | input | SEG_W | Slot receiving the selector |
| ld_sel | input | 16 | Selector value |
| ld_done | output | 1 | One-cycle pulse ending a load |
| ld_fault | output | 2 | Load result: 0 ok, 1 null, 2 table limit |
| acc_valid | input | 1 | Access request |
| acc_seg | input | SEG_W | Slot used by the access |
| acc_offset | input | 32 | Offset within the segment |
| acc_write | input | 1 | 1 for a write access |
| acc_done | output | 1 | One-cycle pulse with the access result |
| acc_fault | output | 2 | 0 ok, 1 null, 2 limit, 3 write-protected |
| acc_linear | output | 32 | Linear address, 0 on fault |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| busy | output | 1 | Descriptor fetch in progress |

## Verification
The bound checker watches, on every cycle, the ordering properties of the fetch and access paths. Reads happen only while busy, and the second read follows the first at +4. Busy rises only after a load request and falls together with the load pulse. An access result follows a request taken while idle, and a faulting access yields a zero address. The bench's scenarios are the only way to show the decoding itself. That covers the table choice, the granularity scaling, the limit boundary, fault priority and the size-bit masking. The scenarios also show that the cache survives table rewrites, faulting loads and loads offered while busy.

// File: rtl/sdu_pkg.sv
package sdu_pkg;

  localparam int ADDR_W = 32;
  localparam int LIM_W  = 20;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NULL  = 2'd1,
    FLT_LIMIT = 2'd2,
    FLT_WPROT = 2'd3
  } fault_e;

  typedef struct packed {
    logic              valid;
    logic              is_null;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [7:0]        rights;
    logic              gran;
    logic              big;
  } slot_t;

  function automatic slot_t unpack_desc(input logic [31:0] w0, input logic [31:0] w1);
    slot_t s;
    s.valid   = 1'b1;
    s.is_null = 1'b0;
    s.base    = {w1[31:24], w1[7:0], w0[31:16]};
    s.limit   = {w1[19:16], w0[15:0]};
    s.rights  = w1[15:8];
    s.gran    = w1[23];
    s.big     = w1[22];
    return s;
  endfunction

  function automatic slot_t null_slot();
    slot_t s;
    s         = '0;
    s.valid   = 1'b1;
    s.is_null = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/sdu_fetch.sv
module sdu_fetch
  import sdu_pkg::*;
#(
  parameter int NUM_SEGS   = 4,
  parameter int NUM_STRICT = 2,
  parameter int TBL_LIM_W  = 16,
  localparam int SEG_W     = $clog2(NUM_SEGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tbl_wr_en,
  input  logic                 tbl_wr_local,
  input  logic [31:0]          tbl_wr_base,
  input  logic [TBL_LIM_W-1:0] tbl_wr_limit,
  input  logic                 ld_valid,
  input  logic [SEG_W-1:0]     ld_seg,
  input  logic [15:0]          ld_sel,
  output logic                 mem_rd_en,
  output logic [31:0]          mem_rd_addr,
  input  logic [31:0]          mem_rd_data,
  output logic                 busy,
  output logic                 wr_en,
  output logic [SEG_W-1:0]     wr_idx,
  output slot_t                wr_slot,
  output logic                 ld_done,
  output fault_e               ld_fault
);

  typedef enum logic [1:0] {S_IDLE, S_REQ_LO, S_REQ_HI, S_CAP_HI} st_e;

  st_e                  state;
  logic [31:0]          gtab_base, ltab_base;
  logic [TBL_LIM_W-1:0] gtab_lim, ltab_lim;
  logic [31:0]          word0_q;
  logic [SEG_W-1:0]     seg_q;

  logic [12:0]          sel_idx;
  logic                 sel_local, sel_null, seg_strict, over_lim;
  logic [31:0]          tab_base, last_byte, tab_lim_ext;

  assign sel_idx     = ld_sel[15:3];
  assign sel_local   = ld_sel[2];
  assign sel_null    = (sel_idx == '0) && !sel_local;
  assign seg_strict  = 32'(ld_seg) < NUM_STRICT;
  assign tab_base    = sel_local ? ltab_base : gtab_base;
  assign tab_lim_ext = sel_local ? 32'(ltab_lim) : 32'(gtab_lim);
  assign last_byte   = {16'h0, sel_idx, 3'b111};
  assign over_lim    = last_byte > tab_lim_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      gtab_base <= '0;
      ltab_base <= '0;
      gtab_lim  <= '0;
      ltab_lim  <= '0;
    end else if (tbl_wr_en) begin
      if (tbl_wr_local) begin
        ltab_base <= tbl_wr_base;
        ltab_lim  <= tbl_wr_limit;
      end else begin
        gtab_base <= tbl_wr_base;
        gtab_lim  <= tbl_wr_limit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mem_rd_addr <= '0;
      word0_q     <= '0;
      seg_q       <= '0;
      ld_done     <= 1'b0;
      ld_fault    <= FLT_NONE;
    end else begin
      ld_done  <= 1'b0;
      ld_fault <= FLT_NONE;
      unique case (state)
        S_IDLE: if (ld_valid) begin
          seg_q <= ld_seg;
          if (sel_null) begin
            ld_done  <= 1'b1;
            ld_fault <= seg_strict ? FLT_NULL : FLT_NONE;
          end else if (over_lim) begin
            ld_done  <= 1'b1;
            ld_fault <= FLT_LIMIT;
          end else begin
            mem_rd_addr <= tab_base + {16'h0, sel_idx, 3'b000};
            state       <= S_REQ_LO;
          end
        end
        S_REQ_LO: begin
          mem_rd_addr <= mem_rd_addr + 32'd4;
          state       <= S_REQ_HI;
        end
        S_REQ_HI: begin
          word0_q <= mem_rd_data;
          state   <= S_CAP_HI;
        end
        S_CAP_HI: begin
          ld_done <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_en = (state == S_REQ_LO) || (state == S_REQ_HI);
  assign busy      = (state != S_IDLE);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = seg_q;
    wr_slot = unpack_desc(word0_q, mem_rd_data);
    if (state == S_CAP_HI) begin
      wr_en = 1'b1;
    end else if (state == S_IDLE && ld_valid && sel_null && !seg_strict) begin
      wr_en   = 1'b1;
      wr_idx  = ld_seg;
      wr_slot = null_slot();
    end
  end

endmodule

// File: rtl/sdu_cache.sv
module sdu_cache
  import sdu_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  localparam int SEG_W   = $clog2(NUM_SEGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  slot_t            wr_slot,
  input  logic [SEG_W-1:0] rd_idx,
  output slot_t            rd_slot
);

  slot_t slots [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slots[g] <= '0;
      end else if (wr_en && 32'(wr_idx) == g) begin
        slots[g] <= wr_slot;
      end
    end
  end

  assign rd_slot = slots[rd_idx];

endmodule

// File: rtl/sdu_check.sv
module sdu_check
  import sdu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic        busy,
  input  slot_t       slot,
  input  logic [31:0] acc_offset,
  input  logic        acc_write,
  output logic        acc_done,
  output fault_e      acc_fault,
  output logic [31:0] acc_linear
);

  logic [31:0] eff_off, eff_lim;
  logic        may_write;
  fault_e      verdict;

  assign eff_off   = slot.big  ? acc_offset : {16'h0, acc_offset[15:0]};
  assign eff_lim   = slot.gran ? {slot.limit, 12'hFFF} : {12'h0, slot.limit};
  assign may_write = !slot.rights[3] && slot.rights[1];

  always_comb begin
    if (!slot.valid || slot.is_null)  verdict = FLT_NULL;
    else if (eff_off > eff_lim)       verdict = FLT_LIMIT;
    else if (acc_write && !may_write) verdict = FLT_WPROT;
    else                              verdict = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_done   <= 1'b0;
      acc_fault  <= FLT_NONE;
      acc_linear <= '0;
    end else begin
      acc_done <= acc_valid && !busy;
      if (acc_valid && !busy) begin
        acc_fault  <= verdict;
        acc_linear <= (verdict == FLT_NONE) ? slot.base + eff_off : '0;
      end
    end
  end

endmodule

// File: rtl/seg_desc_unit.sv
module seg_desc_unit
  import sdu_pkg::*;
#(
  parameter int NUM_SEGS   = 4,
  parameter int NUM_STRICT = 2,
  parameter int TBL_LIM_W  = 16,
  localparam int SEG_W     = $clog2(NUM_SEGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tbl_wr_en,
  input  logic                 tbl_wr_local,
  input  logic [31:0]          tbl_wr_base,
  input  logic [TBL_LIM_W-1:0] tbl_wr_limit,
  input  logic                 ld_valid,
  input  logic [SEG_W-1:0]     ld_seg,
  input  logic [15:0]          ld_sel,
  output logic                 ld_done,
  output logic [1:0]           ld_fault,
  input  logic                 acc_valid,
  input  logic [SEG_W-1:0]     acc_seg,
  input  logic [31:0]          acc_offset,
  input  logic                 acc_write,
  output logic                 acc_done,
  output logic [1:0]           acc_fault,
  output logic [31:0]          acc_linear,
  output logic                 mem_rd_en,
  output logic [31:0]          mem_rd_addr,
  input  logic [31:0]          mem_rd_data,
  output logic                 busy
);

  logic             wr_en;
  logic [SEG_W-1:0] wr_idx;
  slot_t            wr_slot, rd_slot;
  fault_e           ld_fault_e, acc_fault_e;

  sdu_fetch #(.NUM_SEGS(NUM_SEGS), .NUM_STRICT(NUM_STRICT), .TBL_LIM_W(TBL_LIM_W)) u_fetch (
    .clk, .rst, .tbl_wr_en, .tbl_wr_local, .tbl_wr_base, .tbl_wr_limit,
    .ld_valid, .ld_seg, .ld_sel, .mem_rd_en, .mem_rd_addr, .mem_rd_data,
    .busy, .wr_en, .wr_idx, .wr_slot, .ld_done, .ld_fault(ld_fault_e)
  );

  sdu_cache #(.NUM_SEGS(NUM_SEGS)) u_cache (
    .clk, .rst, .wr_en, .wr_idx, .wr_slot, .rd_idx(acc_seg), .rd_slot
  );

  sdu_check u_check (
    .clk, .rst, .acc_valid, .busy, .slot(rd_slot), .acc_offset, .acc_write,
    .acc_done, .acc_fault(acc_fault_e), .acc_linear
  );

  assign ld_fault  = ld_fault_e;
  assign acc_fault = acc_fault_e;

endmodule

// File: rtl/seg_desc_unit_chk.sv
module seg_desc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        ld_valid,
  input logic        ld_done,
  input logic        acc_valid,
  input logic        acc_done,
  input logic [1:0]  acc_fault,
  input logic [31:0] acc_linear,
  input logic        mem_rd_en,
  input logic [31:0] mem_rd_addr,
  input logic        busy
);

  p_read_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);

  p_second_read_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + 32'd4));

  p_fetch_end_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ld_done);

  p_busy_from_load_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ld_valid));

  p_acc_when_idle_r12: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> ($past(acc_valid) && !$past(busy)));

  p_fault_zero_addr_r13: assert property (@(posedge clk) disable iff (rst)
    (acc_done && acc_fault != 2'd0) |-> (acc_linear == 32'd0));

endmodule

bind seg_desc_unit seg_desc_unit_chk u_sdu_chk (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_done(ld_done),
  .acc_valid(acc_valid), .acc_done(acc_done), .acc_fault(acc_fault),
  .acc_linear(acc_linear), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .busy(busy)
);

// File: tb/test_seg_desc_unit.sv
module test_seg_desc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_wr_en = 1'b0, tbl_wr_local = 1'b0;
  logic [31:0] tbl_wr_base = '0;
  logic [15:0] tbl_wr_limit = '0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic        ld_done;
  logic [1:0]  ld_fault;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_seg = '0;
  logic [31:0] acc_offset = '0;
  logic        acc_done;
  logic [1:0]  acc_fault;
  logic [31:0] acc_linear;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        busy;

  always #10 clk = ~clk;

  seg_desc_unit i_seg_desc_unit (.*);

  logic [31:0] mem [256];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];

  logic [31:0] rd_log[$];
  always @(posedge clk) if (!rst && mem_rd_en) rd_log.push_back(mem_rd_addr);

  typedef struct {
    bit        is_acc;
    bit [1:0]  fault;
    bit [31:0] lin;
    string     tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic score(input bit is_acc, input logic [1:0] f, input logic [31:0] lin);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R12 unexpected result: actual kind=%0d fault=%0d lin=%h expected none", is_acc, f, lin);
      return;
    end
    e = exp_q.pop_front();
    if (e.is_acc !== is_acc || e.fault !== f || (is_acc && e.lin !== lin)) begin
      fails++;
      $display("FAIL %s: actual kind=%0d fault=%0d lin=%h expected kind=%0d fault=%0d lin=%h",
               e.tag, is_acc, f, lin, e.is_acc, e.fault, e.lin);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ld_done)  score(1'b0, ld_fault, 32'h0);
      if (acc_done) score(1'b1, acc_fault, acc_linear);
    end
  end

  task automatic put_desc(input int byte_addr, input logic [31:0] base, input logic [19:0] lim,
                          input logic [7:0] rights, input bit g, input bit d);
    mem[byte_addr[9:2]]     = {base[15:0], lim[15:0]};
    mem[byte_addr[9:2] + 1] = {base[31:24], g, d, 2'b00, lim[19:16], rights, base[23:16]};
  endtask

  task automatic set_tbl(input bit local_t, input logic [31:0] base, input logic [15:0] lim);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_local = local_t; tbl_wr_base = base; tbl_wr_limit = lim;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic do_load(input logic [1:0] seg, input logic [15:0] sel, input logic [1:0] f, input string tag);
    exp_t e;
    drain();
    e.is_acc = 1'b0; e.fault = f; e.lin = '0; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = seg; ld_sel = sel;
    @(negedge clk);
    ld_valid = 1'b0;
    drain();
  endtask

  task automatic do_acc(input logic [1:0] seg, input logic [31:0] off, input bit wr,
                        input logic [1:0] f, input logic [31:0] lin, input string tag);
    exp_t e;
    drain();
    e.is_acc = 1'b1; e.fault = f; e.lin = lin; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    acc_valid = 1'b1; acc_seg = seg; acc_offset = off; acc_write = wr;
    do @(negedge clk); while (!acc_done);
    acc_valid = 1'b0; acc_write = 1'b0;
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    exp_t e;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put_desc(32'h008, 32'h0010_0000, 20'h000FF, 8'h92, 0, 1);
    put_desc(32'h010, 32'h1000_0000, 20'h001FF, 8'h92, 1, 1);
    put_desc(32'h018, 32'h2000_0000, 20'hFFFFF, 8'h90, 0, 1);
    put_desc(32'h020, 32'h0040_0000, 20'h0FFFF, 8'h9A, 0, 0);
    put_desc(32'h208, 32'h3000_0000, 20'h00FFF, 8'h92, 0, 1);
    put_desc(32'h210, 32'h0000_5000, 20'h00010, 8'h92, 0, 1);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !ld_done && !acc_done && !mem_rd_en, "R1 reset outputs",
        {28'h0, busy, ld_done, acc_done, mem_rd_en}, 32'h0);
    do_acc(2'd3, 32'h0, 0, 2'd1, 32'h0, "R1 R5 never-loaded slot is null");

    set_tbl(0, 32'h0000_0000, 16'h003F);
    set_tbl(1, 32'h0000_0200, 16'h0017);

    rd_log.delete();
    do_load(2'd2, 16'h0008, 2'd0, "R2 global load");
    chk(rd_log.size() == 2 && rd_log[0] == 32'h008 && rd_log[1] == 32'h00C, "R2 global read addresses",
        rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h008);
    do_acc(2'd2, 32'h20, 0, 2'd0, 32'h0010_0020, "R6 base plus offset");
    do_acc(2'd2, 32'hFF, 1, 2'd0, 32'h0010_00FF, "R8 offset at limit");
    do_acc(2'd2, 32'h100, 0, 2'd2, 32'h0, "R8 R13 offset past limit");

    do_load(2'd3, 16'h0010, 2'd0, "R7 scaled load");
    do_acc(2'd3, 32'h001F_FFFF, 0, 2'd0, 32'h101F_FFFF, "R7 scaled limit top");
    do_acc(2'd3, 32'h0020_0000, 0, 2'd2, 32'h0, "R7 scaled limit exceeded");

    do_load(2'd3, 16'h0018, 2'd0, "R9 read-only load");
    do_acc(2'd3, 32'h40, 1, 2'd3, 32'h0, "R9 write to read-only");
    do_acc(2'd3, 32'h40, 0, 2'd0, 32'h2000_0040, "R9 read of read-only");
    do_acc(2'd3, 32'h0010_0000, 1, 2'd2, 32'h0, "R9 limit outranks write");

    do_load(2'd0, 16'h0020, 2'd0, "R10 code load");
    do_acc(2'd0, 32'h1234_0010, 0, 2'd0, 32'h0040_0010, "R10 upper offset ignored");
    do_acc(2'd0, 32'h10, 1, 2'd3, 32'h0, "R9 write to code");

    rd_log.delete();
    do_load(2'd1, 16'h000E, 2'd0, "R2 local load");
    chk(rd_log.size() == 2 && rd_log[0] == 32'h208 && rd_log[1] == 32'h20C, "R2 local read addresses",
        rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h208);
    do_acc(2'd1, 32'h800, 1, 2'd0, 32'h3000_0800, "R2 local descriptor used");

    do_load(2'd1, 16'h0014, 2'd0, "R3 last entry inside table");
    do_acc(2'd1, 32'h10, 0, 2'd0, 32'h0000_5010, "R3 last entry content");
    rd_log.delete();
    do_load(2'd1, 16'h001C, 2'd2, "R3 local index past limit");
    do_load(2'd2, 16'h0040, 2'd2, "R3 global index past limit");
    chk(rd_log.size() == 0, "R3 no read on table fault", rd_log.size(), 0);
    do_acc(2'd2, 32'h20, 0, 2'd0, 32'h0010_0020, "R3 slot kept after fault");

    rd_log.delete();
    do_load(2'd0, 16'h0003, 2'd1, "R4 null to code slot");
    do_load(2'd1, 16'h0000, 2'd1, "R4 null to stack slot");
    chk(rd_log.size() == 0, "R4 no read on null", rd_log.size(), 0);
    do_acc(2'd0, 32'h10, 0, 2'd0, 32'h0040_0010, "R4 code slot kept");

    put_desc(32'h008, 32'h0ABC_0000, 20'h000FF, 8'h92, 0, 1);
    rd_log.delete();
    do_acc(2'd2, 32'h30, 0, 2'd0, 32'h0010_0030, "R11 cached copy used");
    chk(rd_log.size() == 0, "R11 no read on access", rd_log.size(), 0);
    put_desc(32'h008, 32'h0010_0000, 20'h000FF, 8'h92, 0, 1);

    do_load(2'd2, 16'h0000, 2'd0, "R5 null to data slot");
    do_acc(2'd2, 32'h0, 0, 2'd1, 32'h0, "R5 access via null data slot");

    drain();
    e.is_acc = 1'b0; e.fault = 2'd0; e.lin = '0; e.tag = "R12 load before stalled access";
    exp_q.push_back(e);
    e.is_acc = 1'b1; e.fault = 2'd0; e.lin = 32'h0010_0044; e.tag = "R12 stalled access sees new entry";
    exp_q.push_back(e);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 2'd2; ld_sel = 16'h0008;
    @(negedge clk);
    ld_seg = 2'd3; ld_sel = 16'h0000;
    acc_valid = 1'b1; acc_seg = 2'd2; acc_offset = 32'h44;
    @(negedge clk);
    ld_valid = 1'b0;
    n = 0;
    while (!acc_done && n < 50) begin @(negedge clk); n++; end
    acc_valid = 1'b0;
    drain();
    do_acc(2'd3, 32'h8, 0, 2'd0, 32'h2000_0008, "R12 load offered while busy ignored");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule